// File: doc/BRIEF.md
# UART Interrupt Status and Mask Unit

This unit collects the event sources of a serial port into one 8-bit status word and drives a single interrupt request toward the interrupt controller. Six of the status bits are sticky. Each one is set by its own event strobe from the serial datapath and cleared by its own side-effect strobe, usually a host access to some other register. The two low bits are live mirrors of receiver and transmitter levels. A mask register of the same width selects which status bits may raise the request.

One bus address serves both registers. A host write loads the mask. The status word is always present on `status_o` for the read path. The unit also contains the receive-idle timeout. This counter advances on the baud tick while unread data sits in the receive FIFO below its fullness threshold. It raises the timeout bit after a fixed number of ticks and starts again from zero whenever that bit clears. The transmitter, receiver, FIFOs and baud generator are outside the unit and appear only as strobes and levels.

Top module: `uart_irq_status_unit`

## Requirements
- R1: After reset, `status_o` bits 7..2, the mask and `irq` are all 0.
- R2: Status bit positions: 7 CTS change, 6 autobaud done, 5 receive-FIFO event, 4 transmit-FIFO event, 3 receive timeout, 2 break edge, 1 receive level, 0 transmit level.
- R3: A cycle with `mask_wr` high loads `mask_wdata` into the mask. `irq` is registered and equals the OR of (status AND mask) as it stood one clock earlier. When the mask is 0, `irq` is 0 in the next cycle.
- R4: Bit 7 sets when `cts_in` differs from its value in the previous clock and `cts_irq_en` is 1. A CTS change with `cts_irq_en` at 0 leaves the bit at 0. A `cts_status_read` pulse clears the bit.
- R5: Bit 6 sets on `autobaud_done` and clears on `enable_cmd`.
- R6: Bit 5 sets on `rx_fifo_evt` and clears on `rx_buf_read`. Bit 4 sets on `tx_fifo_evt` and clears on `tx_buf_write`.
- R7: With `rx_fifo_empty`=0, `rx_below_thresh`=1 and `rx_enable`=1, bit 3 sets on the 64th `baud_tick` and stays 0 after 63 ticks. The ticks do not advance the count while the FIFO is at or above its threshold.
- R8: Bit 3 clears, and the tick count returns to zero, when `rx_fifo_empty` is 1, when `rx_char_recv` pulses, or when `rx_enable` is 0. After the bit clears, a full 64 fresh ticks are needed to set it again.
- R9: Bit 2 sets on `break_edge` (break start or end) and clears on `break_ack`.
- R10: Bit 1 equals `rx_ready` when `ffull_sel`=0 and `rx_fifo_full` when `ffull_sel`=1. Bit 0 equals `tx_hold_empty` AND `tx_enable`.
- R11: When the set event and the clear event of one sticky bit arrive in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mask_wr | input | 1 | Host write strobe for the mask |
| mask_wdata | input | 8 | Mask value to load |
| status_o | output | 8 | Status word for the host read path |
| irq | output | 1 | Registered interrupt request |
| cts_in | input | 1 | CTS line level |
| cts_irq_en | input | 1 | Enables the CTS-change event |
| cts_status_read | input | 1 | Host read of the port-change status, clears bit 7 |
| autobaud_done | input | 1 | Baud rate computed and loaded |
| enable_cmd | input | 1 | Host enable command, clears bit 6 |
| rx_fifo_evt | input | 1 | Configured receive-FIFO condition occurred |
| rx_buf_read | input | 1 | Host read of the receive buffer |
| tx_fifo_evt | input | 1 | Configured transmit-FIFO condition occurred |
| tx_buf_write | input | 1 | Host write of the transmit buffer |
| baud_tick | input | 1 | One-cycle pulse per baud period |
| rx_char_recv | input | 1 | A character entered the receive FIFO |
| rx_fifo_empty | input | 1 | Receive FIFO holds no data |
| rx_below_thresh | input | 1 | Receive FIFO fill is below its threshold |
| rx_enable | input | 1 | Receiver enabled |
| break_edge | input | 1 | Break start or end detected |
| break_ack | input | 1 | Host acknowledge of the break change |
| rx_ready | input | 1 | Receiver has a character |
| rx_fifo_full | input | 1 | Receive FIFO full |
| ffull_sel | input | 1 | Selects FIFO-full (1) or ready (0) for bit 1 |
| tx_hold_empty | input | 1 | Transmit holding register empty |
| tx_enable | input | 1 | Transmitter enabled |

## Verification
A sticky bit's set strobe and its clear strobe can fall in the same cycle. The bench raises the receive-FIFO event together with the receive-buffer read and expects bit 5 to read 1 afterwards. The timeout can also fire on the same tick on which a new character arrives. The bench brings the counter to 63 ticks, drives the 64th tick together with `rx_char_recv`, and expects bit 3 to be set. It then checks that a later character clears the bit and that 64 fresh ticks are needed to set it again.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int ST_W  = 8;
  localparam int B_COS = 7;
  localparam int B_ABC = 6;
  localparam int B_RXF = 5;
  localparam int B_TXF = 4;
  localparam int B_RTO = 3;
  localparam int B_DBK = 2;
  localparam int B_RXL = 1;
  localparam int B_TXL = 0;

  // request when any enabled status bit is set
  function automatic logic irq_pending(logic [ST_W-1:0] st, logic [ST_W-1:0] mk);
    return |(st & mk);
  endfunction

  // sticky update, set has priority over clear
  function automatic logic sticky_next(logic q, logic set, logic clr);
    return set | (q & ~clr);
  endfunction
endpackage

// File: rtl/uirq_sticky_bit.sv
module uirq_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  import uirq_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= sticky_next(q_o, set_i, clr_i);
  end

  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  assert_clear_drops_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
  assert_idle_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/uirq_rx_timeout.sv
module uirq_rx_timeout #(
  parameter int TO_TICKS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic baud_tick,
  input  logic waiting_i,
  input  logic flag_i,
  input  logic restart_i,
  output logic fire_o
);
  localparam int CW = (TO_TICKS > 1) ? $clog2(TO_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TO_TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign fire_o = baud_tick && waiting_i && !flag_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                        cnt_q <= '0;
    else if (fire_o || restart_i || !waiting_i || flag_i) cnt_q <= '0;
    else if (baud_tick)                                cnt_q <= cnt_q + 1'b1;
  end

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  assert_fire_rewinds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> (cnt_q == '0));
  assert_restart_rewinds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (cnt_q == '0));
endmodule

// File: rtl/uart_irq_status_unit.sv
module uart_irq_status_unit #(
  parameter int TO_TICKS = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mask_wr,
  input  logic [7:0] mask_wdata,
  output logic [7:0] status_o,
  output logic       irq,
  input  logic       cts_in,
  input  logic       cts_irq_en,
  input  logic       cts_status_read,
  input  logic       autobaud_done,
  input  logic       enable_cmd,
  input  logic       rx_fifo_evt,
  input  logic       rx_buf_read,
  input  logic       tx_fifo_evt,
  input  logic       tx_buf_write,
  input  logic       baud_tick,
  input  logic       rx_char_recv,
  input  logic       rx_fifo_empty,
  input  logic       rx_below_thresh,
  input  logic       rx_enable,
  input  logic       break_edge,
  input  logic       break_ack,
  input  logic       rx_ready,
  input  logic       rx_fifo_full,
  input  logic       ffull_sel,
  input  logic       tx_hold_empty,
  input  logic       tx_enable
);
  import uirq_pkg::*;

  localparam int STICKY_LO = B_DBK;
  localparam int STICKY_HI = B_COS;

  logic [ST_W-1:0] mask_q;
  logic            cts_prev_q, cts_vld_q;
  logic            cts_change;
  logic            rto_fire, rto_restart, rto_waiting;
  logic [STICKY_HI:STICKY_LO] set_vec, clr_vec, sticky_q;

  // CTS edge detect; the first sample after reset is never a change
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_prev_q <= 1'b0;
      cts_vld_q  <= 1'b0;
    end else begin
      cts_prev_q <= cts_in;
      cts_vld_q  <= 1'b1;
    end
  end
  assign cts_change = cts_vld_q && (cts_in != cts_prev_q);

  assign rto_waiting = !rx_fifo_empty && rx_below_thresh && rx_enable;
  assign rto_restart = rx_fifo_empty || rx_char_recv || !rx_enable;

  uirq_rx_timeout #(.TO_TICKS(TO_TICKS)) u_rto (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .waiting_i (rto_waiting),
    .flag_i    (sticky_q[B_RTO]),
    .restart_i (rto_restart),
    .fire_o    (rto_fire)
  );

  always_comb begin
    set_vec = '0;
    clr_vec = '0;
    set_vec[B_COS] = cts_change && cts_irq_en;  clr_vec[B_COS] = cts_status_read;
    set_vec[B_ABC] = autobaud_done;             clr_vec[B_ABC] = enable_cmd;
    set_vec[B_RXF] = rx_fifo_evt;               clr_vec[B_RXF] = rx_buf_read;
    set_vec[B_TXF] = tx_fifo_evt;               clr_vec[B_TXF] = tx_buf_write;
    set_vec[B_RTO] = rto_fire;                  clr_vec[B_RTO] = rto_restart;
    set_vec[B_DBK] = break_edge;                clr_vec[B_DBK] = break_ack;
  end

  for (genvar g = STICKY_LO; g <= STICKY_HI; g++) begin : g_sticky
    uirq_sticky_bit u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_vec[g]),
      .clr_i (clr_vec[g]),
      .q_o   (sticky_q[g])
    );
  end

  assign status_o = {sticky_q,
                     (ffull_sel ? rx_fifo_full : rx_ready),
                     (tx_hold_empty && tx_enable)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      irq    <= 1'b0;
    end else begin
      if (mask_wr) mask_q <= mask_wdata;
      irq <= irq_pending(status_o, mask_q);
    end
  end

  assert_masked_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |=> !irq);
  assert_cos_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[B_COS]) |-> $past(cts_irq_en));
  assert_rto_off_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |=> !status_o[B_RTO]);
endmodule

// File: tb/test_uart_irq_status_unit.sv
module test_uart_irq_status_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mask_wr = 0; logic [7:0] mask_wdata = 0;
  logic [7:0] status_o; logic irq;
  logic cts_in = 0, cts_irq_en = 0, cts_status_read = 0;
  logic autobaud_done = 0, enable_cmd = 0;
  logic rx_fifo_evt = 0, rx_buf_read = 0, tx_fifo_evt = 0, tx_buf_write = 0;
  logic baud_tick = 0, rx_char_recv = 0, rx_fifo_empty = 1, rx_below_thresh = 1, rx_enable = 1;
  logic break_edge = 0, break_ack = 0;
  logic rx_ready = 0, rx_fifo_full = 0, ffull_sel = 0, tx_hold_empty = 0, tx_enable = 0;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  uart_irq_status_unit i_uart_irq_status_unit (.*);

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) baud_tick = 1;
      @(negedge clk) baud_tick = 0;
    end
  endtask

  task automatic t_reset();
    check("R1 sticky bits", status_o & 8'hFC, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
    mask_wdata = 8'hFF; rx_fifo_evt = 1; step();
    rx_fifo_evt = 0; step();
    check("R1 mask zero, irq stays low", {7'b0, irq}, 8'h00);
    rx_buf_read = 1; mask_wdata = 0; step(); rx_buf_read = 0; step();
  endtask

  task automatic t_levels();
    rx_ready = 1; rx_fifo_full = 0; ffull_sel = 0; step();
    check("R10 bit1 ready", status_o & 8'h03, 8'h02);
    ffull_sel = 1; step();
    check("R10 bit1 full sel", status_o & 8'h03, 8'h00);
    rx_fifo_full = 1; rx_ready = 0; step();
    check("R10 bit1 full", status_o & 8'h03, 8'h02);
    tx_hold_empty = 1; tx_enable = 0; step();
    check("R10 bit0 tx disabled", status_o & 8'h01, 8'h00);
    tx_enable = 1; step();
    check("R10 R2 bit0 tx empty", status_o & 8'h01, 8'h01);
    rx_fifo_full = 0; tx_hold_empty = 0; ffull_sel = 0; step();
    check("R2 idle status", status_o, 8'h00);
  endtask

  task automatic t_mask_irq();
    tx_fifo_evt = 1; step(); tx_fifo_evt = 0;
    check("R6 R2 tx fifo bit4", status_o, 8'h10);
    mask_wr = 1; mask_wdata = 8'h10; step(); mask_wr = 0;
    check("R3 irq latency", {7'b0, irq}, 8'h00);
    step();
    check("R3 irq raised", {7'b0, irq}, 8'h01);
    tx_buf_write = 1; step(); tx_buf_write = 0;
    check("R6 tx buf write clears", status_o, 8'h00);
    step();
    check("R3 irq drops", {7'b0, irq}, 8'h00);
    break_edge = 1; step(); break_edge = 0; step();
    check("R3 unmasked bit no irq", {7'b0, irq}, 8'h00);
    check("R9 R2 break bit2", status_o, 8'h04);
    break_ack = 1; step(); break_ack = 0;
    check("R9 break ack clears", status_o, 8'h00);
    mask_wr = 1; mask_wdata = 8'h00; step(); mask_wr = 0;
  endtask

  task automatic t_cos();
    cts_irq_en = 0; cts_in = 1; step();
    check("R4 change while disabled", status_o, 8'h00);
    cts_irq_en = 1; step();
    check("R4 no change no set", status_o, 8'h00);
    cts_in = 0; step();
    check("R4 R2 change sets bit7", status_o, 8'h80);
    cts_status_read = 1; step(); cts_status_read = 0;
    check("R4 read clears", status_o, 8'h00);
    cts_irq_en = 0;
  endtask

  task automatic t_autobaud_rxf();
    autobaud_done = 1; step(); autobaud_done = 0;
    check("R5 R2 autobaud bit6", status_o, 8'h40);
    enable_cmd = 1; step(); enable_cmd = 0;
    check("R5 enable clears", status_o, 8'h00);
    rx_fifo_evt = 1; step(); rx_fifo_evt = 0;
    check("R6 R2 rx fifo bit5", status_o, 8'h20);
    rx_buf_read = 1; step(); rx_buf_read = 0;
    check("R6 rx read clears", status_o, 8'h00);
  endtask

  task automatic t_timeout();
    rx_fifo_empty = 0; rx_below_thresh = 0; rx_enable = 1;
    ticks(70);
    check("R7 above threshold no count", status_o, 8'h00);
    rx_below_thresh = 1; step();
    ticks(63);
    check("R7 63 ticks", status_o, 8'h00);
    ticks(1);
    check("R7 R2 64th tick sets bit3", status_o, 8'h08);
    rx_fifo_empty = 1; step(); rx_fifo_empty = 0;
    check("R8 empty clears", status_o, 8'h00);
    ticks(63);
    check("R8 restart 63", status_o, 8'h00);
    ticks(1);
    check("R8 restart 64", status_o, 8'h08);
    rx_enable = 0; step(); rx_enable = 1;
    check("R8 disable clears", status_o, 8'h00);
    ticks(64);
    check("R8 re-arm", status_o, 8'h08);
    rx_char_recv = 1; step(); rx_char_recv = 0;
    check("R8 char clears", status_o, 8'h00);
    ticks(40);
    rx_char_recv = 1; step(); rx_char_recv = 0;
    ticks(63);
    check("R8 char restarts count", status_o, 8'h00);
    ticks(1);
    check("R8 full count after char", status_o, 8'h08);
    rx_fifo_empty = 1; step();
  endtask

  task automatic t_set_wins();
    rx_fifo_evt = 1; rx_buf_read = 1; step();
    rx_fifo_evt = 0; rx_buf_read = 0;
    check("R11 rx fifo set beats read", status_o, 8'h20);
    rx_buf_read = 1; step(); rx_buf_read = 0;
    autobaud_done = 1; enable_cmd = 1; step();
    autobaud_done = 0; enable_cmd = 0;
    check("R11 autobaud set beats enable", status_o, 8'h40);
    enable_cmd = 1; step(); enable_cmd = 0;
    rx_fifo_empty = 0; step();
    ticks(63);
    @(negedge clk) begin baud_tick = 1; rx_char_recv = 1; end
    @(negedge clk) begin baud_tick = 0; rx_char_recv = 0; end
    check("R11 timeout beats char", status_o, 8'h08);
    rx_fifo_empty = 1; step();
    check("R11 cleanup", status_o, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    t_reset();
    t_levels();
    t_mask_irq();
    t_cos();
    t_autobaud_rxf();
    t_timeout();
    t_set_wins();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule